// File: doc/BRIEF.md
# Interrupt Vector Receive Register

This block accepts an interrupt vector from an interrupt source and holds it for the processor until the source withdraws it. A source announces a vector with a one-cycle raise strobe and a small source number. If the block is idle, it records the vector in three data words, sets a busy flag and drives a pending line toward the interrupt arbiter. The source later withdraws the vector with a one-cycle lower strobe, which drops the busy flag and the pending line.

The block has room for exactly one vector. The busy flag guards that single slot: a raise that arrives while a vector is held is dropped and leaves the stored words untouched. The processor reads a status word or one of the three data words through a two-bit select. The read path is combinational from the registers. The first data word carries a fixed five-bit all-ones tag placed just above the source number.

Top module: `ivec_rx_reg`

## Requirements
- R1: The status word has the busy flag at bit 5 (value 0x20) and zeros in every other bit. `pending_o` always equals the busy flag.
- R2: A raise strobe while busy is clear sets busy and `pending_o` at the next clock edge.
- R3: A raise strobe while busy is set is ignored. Busy stays set, and all three data words keep their values.
- R4: On capture, data word 0 becomes (0x1f << 6) | source: bits 10:6 are all ones, bits 5:0 hold the 6-bit source number, and all higher bits are zero.
- R5: On capture, data words 1 and 2 become zero.
- R6: A lower strobe while busy is set clears busy and `pending_o` at the next edge. The data words keep the captured vector.
- R7: A lower strobe while busy is clear has no effect on status or data.
- R8: When raise and lower arrive in the same cycle, each is judged against the busy value before the edge. From idle, the vector is captured and busy is set. From busy, busy is cleared and no data is captured.
- R9: After reset, busy is clear, `pending_o` is low and all three data words are zero.
- R10: The read select `rd_sel_i` picks the word on `rd_data_o` combinationally: 0 selects status, 1 selects data word 0, 2 selects data word 1 and 3 selects data word 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 1 | One-cycle strobe offering a vector |
| lower_i | input | 1 | One-cycle strobe withdrawing the vector |
| src_i | input | SRC_W (6) | Source number carried with a raise |
| rd_sel_i | input | 2 | Read select: status, word 0, word 1, word 2 |
| rd_data_o | output | DATA_W (64) | Selected word, zero-extended |
| pending_o | output | 1 | Vector held, request to the arbiter |

## Verification
A wrong busy flag shows up on `pending_o` and on status bit 5 one edge after the strobe that disturbed it. The next raise then also shows the fault in data word 0: a lost flag lets that raise overwrite the held vector, and a stuck flag blocks a capture. A wrong capture path shows up in data word 0 at the first read after the capture edge. The bench sweeps every source number through capture, blocked raise, withdrawal and idle withdrawal. It also drives both simultaneous-strobe orderings, so each of these faults appears within one or two cycles of its cause.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int BUSY_BIT = 5;
    localparam int STAT_W   = 8;
    localparam int TAG_W    = 5;
    localparam int NWORDS   = 3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_WORD0  = 2'd1,
        SEL_WORD1  = 2'd2,
        SEL_WORD2  = 2'd3
    } ivr_sel_e;

    typedef struct packed {
        logic busy;
    } ivr_ctrl_t;

endpackage

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
    import ivr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raise_i,
    input  logic lower_i,
    output logic busy_o,
    output logic capture_o
);

    ivr_ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        capture_o = raise_i && !st_q.busy;
        if (capture_o) begin
            st_d.busy = 1'b1;
        end else if (lower_i && st_q.busy) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/ivr_words.sv
module ivr_words
    import ivr_pkg::*;
#(
    parameter int SRC_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          capture_i,
    input  logic [SRC_W-1:0]              src_i,
    output logic [NWORDS-1:0][DATA_W-1:0] words_o
);

    localparam int TAG_LSB = SRC_W;
    localparam logic [TAG_W-1:0] TAG_VAL = '1;

    typedef struct packed {
        logic [NWORDS-1:0][DATA_W-1:0] w;
    } words_t;

    words_t wd_d, wd_q;
    logic [NWORDS-1:0][DATA_W-1:0] load_val;

    for (genvar i = 0; i < NWORDS; i++) begin : g_load
        if (i == 0) begin : g_first
            always_comb begin
                load_val[i] = '0;
                load_val[i][SRC_W-1:0] = src_i;
                load_val[i][TAG_LSB +: TAG_W] = TAG_VAL;
            end
        end else begin : g_rest
            assign load_val[i] = '0;
        end
    end

    always_comb begin
        wd_d = wd_q;
        if (capture_i) begin
            wd_d.w = load_val;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign words_o = wd_q.w;

endmodule

// File: rtl/ivr_rdmux.sv
module ivr_rdmux
    import ivr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]                    sel_i,
    input  logic [STAT_W-1:0]             status_i,
    input  logic [NWORDS-1:0][DATA_W-1:0] words_i,
    output logic [DATA_W-1:0]             data_o
);

    always_comb begin
        data_o = '0;
        unique case (ivr_sel_e'(sel_i))
            SEL_STATUS: data_o[STAT_W-1:0] = status_i;
            SEL_WORD0:  data_o = words_i[0];
            SEL_WORD1:  data_o = words_i[1];
            SEL_WORD2:  data_o = words_i[2];
            default:    data_o = '0;
        endcase
    end

endmodule

// File: rtl/ivec_rx_reg.sv
module ivec_rx_reg
    import ivr_pkg::*;
#(
    parameter int SRC_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              raise_i,
    input  logic              lower_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [1:0]        rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              pending_o
);

    logic                          busy;
    logic                          capture;
    logic [NWORDS-1:0][DATA_W-1:0] words;
    logic [STAT_W-1:0]             status;
    logic [DATA_W-1:0]             word0;

    ivr_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .raise_i   (raise_i),
        .lower_i   (lower_i),
        .busy_o    (busy),
        .capture_o (capture)
    );

    ivr_words #(
        .SRC_W  (SRC_W),
        .DATA_W (DATA_W)
    ) u_words (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .src_i     (src_i),
        .words_o   (words)
    );

    always_comb begin
        status           = '0;
        status[BUSY_BIT] = busy;
    end

    assign word0 = words[0];

    ivr_rdmux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .sel_i    (rd_sel_i),
        .status_i (status),
        .words_i  (words),
        .data_o   (rd_data_o)
    );

    assign pending_o = busy;

endmodule

// File: rtl/ivr_checker.sv
module ivr_checker
    import ivr_pkg::*;
#(
    parameter int SRC_W  = 6,
    parameter int DATA_W = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              raise_i,
    input logic              lower_i,
    input logic [SRC_W-1:0]  src_i,
    input logic              pending_o,
    input logic [STAT_W-1:0] status,
    input logic [DATA_W-1:0] word0
);

    always_comb begin
        if (rst_ni) begin
            p_status_pending_r1: assert (status[BUSY_BIT] == pending_o);
        end
    end

    p_idle_raise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pending_o && raise_i) |=> pending_o);

    p_busy_raise_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && raise_i && !lower_i) |=> (pending_o && $stable(word0)));

    p_capture_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pending_o && raise_i) |=>
            (word0[SRC_W-1:0] == $past(src_i) && word0[SRC_W +: TAG_W] == '1));

    p_lower_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && lower_i) |=> (!pending_o && $stable(word0)));

    p_idle_lower_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pending_o && lower_i && !raise_i) |=> (!pending_o && $stable(word0)));

endmodule

bind ivec_rx_reg ivr_checker #(
    .SRC_W  (SRC_W),
    .DATA_W (DATA_W)
) u_ivr_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raise_i   (raise_i),
    .lower_i   (lower_i),
    .src_i     (src_i),
    .pending_o (pending_o),
    .status    (status),
    .word0     (word0)
);

// File: tb/ivec_rx_reg_test.sv
module ivec_rx_reg_test;

    localparam int SRC_W  = 6;
    localparam int DATA_W = 64;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              raise_i = 1'b0;
    logic              lower_i = 1'b0;
    logic [SRC_W-1:0]  src_i = '0;
    logic [1:0]        rd_sel_i = 2'd0;
    logic [DATA_W-1:0] rd_data_o;
    logic              pending_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    ivec_rx_reg #(.SRC_W(SRC_W), .DATA_W(DATA_W)) uut (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .raise_i   (raise_i),
        .lower_i   (lower_i),
        .src_i     (src_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .pending_o (pending_o)
    );

    always #5 clk_i = ~clk_i;

    task automatic check(input string req, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DATA_W-1:0] v);
        rd_sel_i = sel;
        #1;
        v = rd_data_o;
    endtask

    task automatic cyc(input logic r, input logic l, input logic [SRC_W-1:0] s);
        raise_i = r;
        lower_i = l;
        src_i   = s;
        @(posedge clk_i);
        #2;
        raise_i = 1'b0;
        lower_i = 1'b0;
    endtask

    task automatic check_all(input string req, input logic busy,
                             input logic [DATA_W-1:0] w0);
        logic [DATA_W-1:0] v;
        check({req, " pending"}, {63'd0, pending_o}, {63'd0, busy});
        rd(2'd0, v);
        check({req, " status"}, v, busy ? 64'h20 : 64'h0);
        rd(2'd1, v);
        check({req, " word0"}, v, w0);
        rd(2'd2, v);
        check({req, " word1 R5"}, v, 64'h0);
        rd(2'd3, v);
        check({req, " word2 R5"}, v, 64'h0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] w0;
        repeat (3) @(posedge clk_i);
        #2;
        check_all("R9 reset", 1'b0, 64'h0);
        rst_ni = 1'b1;
        cyc(1'b0, 1'b1, '0);
        check_all("R7 idle lower after reset", 1'b0, 64'h0);

        for (int s = 0; s < 64; s++) begin
            w0 = 64'(31 * 64 + s);
            cyc(1'b1, 1'b0, SRC_W'(s));
            check_all("R2 R4 R10 capture", 1'b1, w0);
            cyc(1'b1, 1'b0, SRC_W'(63 - s));
            check_all("R3 busy raise ignored", 1'b1, w0);
            cyc(1'b0, 1'b1, '0);
            check_all("R6 lower", 1'b0, w0);
            cyc(1'b0, 1'b1, '0);
            check_all("R7 idle lower", 1'b0, w0);
        end

        w0 = 64'(31 * 64 + 9);
        cyc(1'b1, 1'b1, 6'd9);
        check_all("R8 both from idle", 1'b1, w0);
        cyc(1'b1, 1'b1, 6'd40);
        check_all("R8 both from busy", 1'b0, w0);
        check("R1 pending vs status", {63'd0, pending_o}, 64'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule